// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block connects a synchronous client to an asynchronous extended-data-out dynamic RAM with two byte lanes. The client presents one word request at a time over a valid/ready handshake. A request carries a word address, a byte-lane mask and an operation: a read, an early write, or a read followed by an early write to the same location. The controller splits the address into a row part and a column part and drives them in turn on a shared address bus. It opens the row with the row strobe and accesses the column with one column strobe per byte lane.

Every strobe interval is a parameter counted in controller clock cycles. These are the row-to-column delay, the column pulse width, the column precharge, the row precharge, the minimum and maximum row-open times, and the read access latency. A request that hits the open row while there is still enough row-open time left reuses the row without a new row strobe (page mode). Any other request closes the row first and waits out the row precharge. Writes are always early writes: write-enable falls one cycle before the column strobe, and the output enable stays high for the whole write. Read data comes back with a one-cycle valid pulse.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The request address splits into row = `req_addr[ROW_W+COL_W-1:COL_W]` and column = `req_addr[COL_W-1:0]`, both zero-extended onto `dram_addr`. The row is on the bus in the cycle before `dram_ras_n` falls and stays unchanged there. The column is on the bus in the cycle before any column strobe falls and stays unchanged while a column strobe is low.
- R2: A column strobe falls only while `dram_ras_n` is low, and at least T_RCD cycles after `dram_ras_n` fell.
- R3: Each column strobe pulse is low for exactly T_CAS cycles in a write and exactly max(T_CAS, T_ACC) cycles in a read.
- R4: A read keeps `dram_we_n` high, drives `dram_oe_n` low while the column strobe is low, and samples `dram_dq_in` in the last low cycle. `rd_valid` is then high for exactly one cycle with the sampled data on `rd_data`.
- R5: In a write, `dram_we_n` is already low in the cycle before the column strobe falls. `dram_oe_n` is high whenever `dram_we_n` is low. `dram_dq_oe` is high only while `dram_we_n` is low.
- R6: `req_be[0]` enables `dram_lcas_n` and data bits [LANE_W-1:0]. `req_be[1]` enables `dram_ucas_n` and bits [DATA_W-1:LANE_W]. A disabled lane is neither read nor written, and it returns zero on `rd_data`.
- R7: A request to the row that is already open, accepted while the row has enough open time left, is served without another falling edge on `dram_ras_n`.
- R8: A request to a different row closes the open row and then reopens it with a new row strobe.
- R9: `dram_ras_n` is never low for fewer than T_RAS_MIN cycles.
- R10: `dram_ras_n` is never low for more than T_RAS_MAX cycles. If no request arrives, the controller closes the row on its own before that limit.
- R11: After `dram_ras_n` rises, it stays high for at least T_RP cycles.
- R12: Between two column strobe pulses, the strobes stay high for at least T_CP cycles.
- R13: With `req_rmw` set, the controller reads the location, returns the old data through `rd_valid`/`rd_data`, and then early-writes `req_wdata` to the same column under the same row-open period.
- R14: During and right after reset, all strobes, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_write | input | 1 | 1 = write, 0 = read (ignored when req_rmw) |
| req_rmw | input | 1 | Read then write the same word |
| req_be | input | 2 | Byte-lane enables, bit 1 = upper lane |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DATA_W | Read data, disabled lanes zero |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-lane column strobe, active low |
| dram_lcas_n | output | 1 | Lower-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Write data to the pad |
| dram_dq_oe | output | 1 | Pad drive enable |
| dram_dq_in | input | DATA_W | Data from the pad |

## Verification
The assertions assume that the DRAM delivers valid data within T_ACC cycles of a column strobe falling. They also assume that requests hold their fields stable while `req_valid` is high and not yet accepted, and that reset starts with the memory already precharged. The bench's memory model drives a poison word until T_ACC low cycles have passed, so a controller that samples too early returns wrong data. Requests are driven only at falling clock edges and held until ready is seen. The sweeps cover every address of a small 3-bit-row, 3-bit-column configuration with full, single-lane and read-write-back operations.

// File: rtl/edo_pkg.sv
package edo_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROWSET,
      ST_RCD,
      ST_COLSET,
      ST_CASLO,
      ST_CASPRE,
      ST_PAGE,
      ST_PRE
   } edo_state_e;

   function automatic int edo_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
   parameter int ROW_W = 10,
   parameter int COL_W = 9
) (
   input  logic [ROW_W+COL_W-1:0] addr,
   output logic [ROW_W-1:0]       row,
   output logic [COL_W-1:0]       col
);
   assign row = addr[ROW_W+COL_W-1:COL_W];
   assign col = addr[COL_W-1:0];
endmodule

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val - W'(1);
      else if (cnt != '0)
         cnt <= cnt - W'(1);
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/edo_ras_age.sv
module edo_ras_age #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         run,
   output logic [W-1:0] age
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age <= '0;
      else if (start)
         age <= W'(1);
      else if (!run)
         age <= '0;
      else if (age != '1)
         age <= age + W'(1);
   end
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
   import edo_pkg::*;
#(
   parameter int ROW_W     = 10,
   parameter int COL_W     = 9,
   parameter int DATA_W    = 16,
   parameter int T_RCD     = 2,
   parameter int T_CAS     = 2,
   parameter int T_CP      = 1,
   parameter int T_RP      = 3,
   parameter int T_RAS_MIN = 8,
   parameter int T_RAS_MAX = 400,
   parameter int T_ACC     = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [ROW_W+COL_W-1:0] req_addr,
   input  logic                   req_write,
   input  logic                   req_rmw,
   input  logic [1:0]             req_be,
   input  logic [DATA_W-1:0]      req_wdata,
   output logic                   rd_valid,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   dram_ras_n,
   output logic                   dram_ucas_n,
   output logic                   dram_lcas_n,
   output logic                   dram_we_n,
   output logic                   dram_oe_n,
   output logic [edo_max(ROW_W,COL_W)-1:0] dram_addr,
   output logic [DATA_W-1:0]      dram_dq_out,
   output logic                   dram_dq_oe,
   input  logic [DATA_W-1:0]      dram_dq_in
);
   localparam int DA_W       = edo_max(ROW_W, COL_W);
   localparam int LANE_W     = DATA_W / 2;
   localparam int T_CRD      = edo_max(T_CAS, T_ACC);
   localparam int COL_BUDGET = 2 * (1 + T_CRD + T_CP);
   localparam int TMAX       = edo_max(edo_max(T_RCD, T_CRD), edo_max(T_CP, T_RP));
   localparam int TW         = $clog2(TMAX + 1) + 1;
   localparam int AGE_W      = $clog2(T_RAS_MAX + COL_BUDGET + 1) + 1;

   // elaboration-time parameter checks
   if (DATA_W < 2 || (DATA_W % 2) != 0)
      $error("DATA_W must be even and at least 2");
   if (T_RCD < 1 || T_CAS < 1 || T_CP < 1 || T_RP < 1 || T_ACC < 1 || T_RAS_MIN < 1)
      $error("every timing count must be at least one cycle");
   if (T_RAS_MAX < T_RCD + T_RAS_MIN + COL_BUDGET)
      $error("T_RAS_MAX leaves no room for one full column cycle");

   edo_state_e state, nxt;

   logic [ROW_W-1:0]  req_row, open_row;
   logic [COL_W-1:0]  req_col, col_q;
   logic [1:0]        be_q;
   logic [DATA_W-1:0] wdata_q, rd_q, lane_mask;
   logic              wr_q, rmw_q, second_q, rd_valid_q;
   logic              t_load, t_done;
   logic [TW-1:0]     t_val;
   logic [AGE_W-1:0]  age;
   logic              hit, expire, old_enough, accept, wr_phase, close_req;
   logic [1:0]        cas_n;

   edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
      .addr (req_addr),
      .row  (req_row),
      .col  (req_col)
   );

   edo_phase_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   edo_ras_age #(.W(AGE_W)) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .start (state == ST_ROWSET && t_done),
      .run   (!dram_ras_n),
      .age   (age)
   );

   assign hit        = (req_row == open_row);
   assign expire     = (age > AGE_W'(T_RAS_MAX - COL_BUDGET));
   assign old_enough = (age >= AGE_W'(T_RAS_MIN));
   assign req_ready  = (state == ST_IDLE) || (state == ST_PAGE && hit && !expire);
   assign accept     = req_valid && req_ready;
   assign wr_phase   = rmw_q ? second_q : wr_q;
   assign close_req  = expire || (req_valid && !hit);

   always_comb begin
      nxt    = state;
      t_load = 1'b0;
      t_val  = TW'(1);
      unique case (state)
         ST_IDLE:   if (accept) begin nxt = ST_ROWSET; t_load = 1'b1; end
         ST_ROWSET: if (t_done) begin nxt = ST_RCD; t_load = 1'b1; t_val = TW'(T_RCD); end
         ST_RCD:    if (t_done) begin nxt = ST_COLSET; t_load = 1'b1; end
         ST_COLSET: if (t_done) begin
            nxt    = ST_CASLO;
            t_load = 1'b1;
            t_val  = wr_phase ? TW'(T_CAS) : TW'(T_CRD);
         end
         ST_CASLO:  if (t_done) begin nxt = ST_CASPRE; t_load = 1'b1; t_val = TW'(T_CP); end
         ST_CASPRE: if (t_done) begin
            if (rmw_q && !second_q) begin nxt = ST_COLSET; t_load = 1'b1; end
            else nxt = ST_PAGE;
         end
         ST_PAGE: begin
            if (accept) begin
               nxt = ST_COLSET; t_load = 1'b1;
            end else if (close_req && old_enough) begin
               nxt = ST_PRE; t_load = 1'b1; t_val = TW'(T_RP);
            end
         end
         ST_PRE:    if (t_done) nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   for (genvar g = 0; g < 2; g++) begin : g_lane
      assign cas_n[g] = !(state == ST_CASLO && be_q[g]);
      assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{be_q[g]}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         open_row   <= '0;
         col_q      <= '0;
         be_q       <= '0;
         wdata_q    <= '0;
         wr_q       <= 1'b0;
         rmw_q      <= 1'b0;
         second_q   <= 1'b0;
         rd_q       <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         state      <= nxt;
         rd_valid_q <= 1'b0;
         if (accept) begin
            open_row <= req_row;
            col_q    <= req_col;
            be_q     <= req_be;
            wdata_q  <= req_wdata;
            wr_q     <= req_write;
            rmw_q    <= req_rmw;
            second_q <= 1'b0;
         end
         if (state == ST_CASPRE && t_done && rmw_q && !second_q)
            second_q <= 1'b1;
         if (state == ST_CASLO && t_done && !wr_phase) begin
            rd_q       <= dram_dq_in & lane_mask;
            rd_valid_q <= 1'b1;
         end
      end
   end

   assign dram_ras_n  = (state inside {ST_IDLE, ST_ROWSET, ST_PRE});
   assign dram_lcas_n = cas_n[0];
   assign dram_ucas_n = cas_n[1];
   assign dram_we_n   = !(wr_phase && (state inside {ST_COLSET, ST_CASLO}));
   assign dram_oe_n   = !(state == ST_CASLO && !wr_phase);
   assign dram_dq_oe  = wr_phase && (state inside {ST_COLSET, ST_CASLO});
   assign dram_dq_out = wdata_q;
   assign dram_addr   = (state inside {ST_IDLE, ST_ROWSET, ST_RCD, ST_PRE})
                        ? DA_W'(open_row) : DA_W'(col_q);
   assign rd_valid    = rd_valid_q;
   assign rd_data     = rd_q;
endmodule

// File: rtl/edo_dram_chk.sv
module edo_dram_chk #(
   parameter int DA_W      = 10,
   parameter int T_RCD     = 2,
   parameter int T_CP      = 1,
   parameter int T_RP      = 3,
   parameter int T_RAS_MIN = 8,
   parameter int T_RAS_MAX = 400
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dram_ras_n,
   input logic            dram_ucas_n,
   input logic            dram_lcas_n,
   input logic            dram_we_n,
   input logic            dram_oe_n,
   input logic            dram_dq_oe,
   input logic [DA_W-1:0] dram_addr,
   input logic            rd_valid
);
   localparam int CW = $clog2(T_RAS_MAX + T_RP + T_CP + T_RCD + 2) + 1;

   logic          cas_low, cas_q, ras_q;
   logic [CW-1:0] lo_cnt, hi_cnt, chi_cnt;

   assign cas_low = !dram_ucas_n || !dram_lcas_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q   <= 1'b1;
         cas_q   <= 1'b0;
         lo_cnt  <= '0;
         hi_cnt  <= CW'(T_RP);
         chi_cnt <= CW'(T_CP);
      end else begin
         ras_q <= dram_ras_n;
         cas_q <= cas_low;
         if (!dram_ras_n) begin
            hi_cnt <= '0;
            if (lo_cnt != '1) lo_cnt <= lo_cnt + CW'(1);
         end else begin
            lo_cnt <= '0;
            if (hi_cnt != '1) hi_cnt <= hi_cnt + CW'(1);
         end
         if (cas_low) chi_cnt <= '0;
         else if (chi_cnt != '1) chi_cnt <= chi_cnt + CW'(1);
      end
   end

   // R1: address steady while a column strobe is low, and across the row strobe fall
   a_r1_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
      cas_low |-> $stable(dram_addr));
   a_r1_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_ras_n && ras_q) |-> $stable(dram_addr));
   // R2: column strobe only inside the row-open period, after the row delay
   a_r2_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
      cas_low |-> !dram_ras_n);
   a_r2_rcd: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_low && !cas_q && !dram_ras_n) |-> (lo_cnt >= CW'(T_RCD)));
   // R4: read valid is a single-cycle pulse
   a_r4_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   // R5: early write and output-enable rules
   a_r5_early_we: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_low && !cas_q && !dram_we_n) |-> $past(!dram_we_n));
   a_r5_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> dram_oe_n);
   a_r5_drive_only_write: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> (!dram_we_n && !dram_ras_n));
   // R9 and R10: row-open window
   a_r9_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_ras_n && !ras_q) |-> (lo_cnt >= CW'(T_RAS_MIN)));
   a_r10_ras_max: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_ras_n |-> (lo_cnt < CW'(T_RAS_MAX)));
   // R11: row precharge
   a_r11_ras_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_ras_n && ras_q) |-> (hi_cnt >= CW'(T_RP)));
   // R12: column precharge
   a_r12_cas_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_low && !cas_q) |-> (chi_cnt >= CW'(T_CP)));
endmodule

bind edo_dram_ctrl edo_dram_chk #(
   .DA_W      (DA_W),
   .T_RCD     (T_RCD),
   .T_CP      (T_CP),
   .T_RP      (T_RP),
   .T_RAS_MIN (T_RAS_MIN),
   .T_RAS_MAX (T_RAS_MAX)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dram_ras_n  (dram_ras_n),
   .dram_ucas_n (dram_ucas_n),
   .dram_lcas_n (dram_lcas_n),
   .dram_we_n   (dram_we_n),
   .dram_oe_n   (dram_oe_n),
   .dram_dq_oe  (dram_dq_oe),
   .dram_addr   (dram_addr),
   .rd_valid    (rd_valid)
);

// File: tb/sim_edo_dram_ctrl.sv
module sim_edo_dram_ctrl;
   localparam int ROW_W = 3, COL_W = 3, DATA_W = 16;
   localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3;
   localparam int T_RAS_MIN = 8, T_RAS_MAX = 40, T_ACC = 3;
   localparam int T_CRD = (T_CAS > T_ACC) ? T_CAS : T_ACC;
   localparam int NW = 1 << (ROW_W + COL_W);

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_rmw = 1'b0;
   logic [ROW_W+COL_W-1:0] req_addr = '0;
   logic [1:0] req_be = 2'b11;
   logic [DATA_W-1:0] req_wdata = '0;
   logic req_ready, rd_valid;
   logic [DATA_W-1:0] rd_data, dram_dq_out;
   logic [DATA_W-1:0] dram_dq_in = 16'hDEAD;
   logic dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [2:0] dram_addr;

   always #10 clk = ~clk;

   edo_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
      .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN),
      .T_RAS_MAX(T_RAS_MAX), .T_ACC(T_ACC)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_rmw(req_rmw), .req_be(req_be),
      .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
      .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
      .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

   int total = 0, bad = 0;
   bit finished = 1'b0;
   logic [DATA_W-1:0] dmem [NW];
   logic [DATA_W-1:0] shadow [NW];

   // monitor and DRAM model state
   int ras_falls = 0, cas_pulses = 0, wr_pulses = 0;
   int v_rcd = 0, v_width = 0, v_early = 0, v_oe = 0, v_min = 0, v_max = 0, v_rp = 0, v_cp = 0;
   int ras_lo_run = 0, ras_hi_run = 100, cas_lo_run = 0, cas_hi_run = 100, acc = 0;
   bit prev_ras = 1'b1, prev_cas = 1'b0, prev_we = 1'b1, first_cas = 1'b0, fall_we = 1'b0;
   logic [2:0] mrow = '0, mcol = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit cas_low = !dram_ucas_n || !dram_lcas_n;
         if (!dram_ras_n && prev_ras) begin
            ras_falls++;
            if (ras_hi_run < T_RP) v_rp++;
            ras_lo_run = 0; first_cas = 1'b1; mrow = dram_addr;
         end
         if (dram_ras_n && !prev_ras) begin
            if (ras_lo_run < T_RAS_MIN) v_min++;
            if (ras_lo_run > T_RAS_MAX) v_max++;
            ras_hi_run = 0;
         end
         if (cas_low && !prev_cas) begin
            if (first_cas) begin
               if (ras_lo_run < T_RCD) v_rcd++;
               first_cas = 1'b0;
            end else if (cas_hi_run < T_CP) v_cp++;
            if (dram_ras_n) v_rcd++;
            fall_we = !dram_we_n;
            if (!dram_we_n && prev_we) v_early++;
            mcol = dram_addr; cas_lo_run = 0; acc = 0;
            if (!dram_we_n) begin
               wr_pulses++;
               if (!dram_dq_oe) v_early++;
               if (!dram_lcas_n) dmem[{mrow, mcol}][7:0]  = dram_dq_out[7:0];
               if (!dram_ucas_n) dmem[{mrow, mcol}][15:8] = dram_dq_out[15:8];
            end
         end
         if (!cas_low && prev_cas) begin
            cas_pulses++;
            if (cas_lo_run != (fall_we ? T_CAS : T_CRD)) v_width++;
            cas_hi_run = 0;
         end
         if (!dram_we_n && !dram_oe_n) v_oe++;
         if (dram_dq_oe && dram_we_n) v_oe++;
         if (!dram_ras_n) ras_lo_run++; else ras_hi_run++;
         if (cas_low) begin cas_lo_run++; acc++; end else cas_hi_run++;
         dram_dq_in = (!dram_oe_n && cas_low && acc >= T_ACC) ? dmem[{mrow, mcol}] : 16'hDEAD;
         prev_ras = dram_ras_n; prev_cas = cas_low; prev_we = dram_we_n;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic issue(input int a, input bit wr, input bit rmw,
                        input logic [1:0] be, input logic [DATA_W-1:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_addr = (ROW_W+COL_W)'(a); req_write = wr;
      req_rmw = rmw; req_be = be; req_wdata = wd;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic get_rd(output logic [DATA_W-1:0] d);
      do @(negedge clk); while (!rd_valid);
      d = rd_data;
   endtask

   function automatic logic [DATA_W-1:0] pat(input int a, input int k);
      return DATA_W'(a * 16'h1357 + k * 16'h0F1 + 16'h2468);
   endfunction

   function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old,
         input logic [DATA_W-1:0] nw, input logic [1:0] be);
      return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1; total++; bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DATA_W-1:0] d;
      int r0;
      for (int i = 0; i < NW; i++) begin dmem[i] = '0; shadow[i] = '0; end
      repeat (3) @(negedge clk);
      // R14: reset values
      check(dram_ras_n && dram_ucas_n && dram_lcas_n && dram_we_n && dram_oe_n,
            "R14 strobes in reset", 0, 1);
      check(!dram_dq_oe && !rd_valid, "R14 drive/valid in reset", 1, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && dram_ras_n, "R14 ready after reset", int'(req_ready), 1);

      // R1 R5: full-word write sweep
      for (int a = 0; a < NW; a++) begin
         issue(a, 1'b1, 1'b0, 2'b11, pat(a, 0));
         shadow[a] = pat(a, 0);
      end
      // R1 R4: full-word read sweep
      for (int a = 0; a < NW; a++) begin
         issue(a, 1'b0, 1'b0, 2'b11, '0);
         get_rd(d);
         check(d == shadow[a], $sformatf("R1 R4 read addr %0d", a), int'(d), int'(shadow[a]));
      end
      // R6: single-lane writes, alternate lanes
      for (int a = 0; a < NW; a++) begin
         automatic logic [1:0] be = (a % 2) ? 2'b10 : 2'b01;
         issue(a, 1'b1, 1'b0, be, pat(a, 1));
         shadow[a] = lane_merge(shadow[a], pat(a, 1), be);
      end
      for (int a = 0; a < NW; a++) begin
         issue(a, 1'b0, 1'b0, 2'b11, '0);
         get_rd(d);
         check(d == shadow[a], $sformatf("R6 lane write addr %0d", a), int'(d), int'(shadow[a]));
      end
      // R6: single-lane reads return zero in the disabled lane
      for (int a = 0; a < NW; a += 7) begin
         issue(a, 1'b0, 1'b0, 2'b01, '0);
         get_rd(d);
         check(d == {8'h00, shadow[a][7:0]}, "R6 lower-lane read", int'(d), int'({8'h00, shadow[a][7:0]}));
         issue(a, 1'b0, 1'b0, 2'b10, '0);
         get_rd(d);
         check(d == {shadow[a][15:8], 8'h00}, "R6 upper-lane read", int'(d), int'({shadow[a][15:8], 8'h00}));
      end
      // R13: read then write back
      for (int a = 0; a < NW; a += 5) begin
         issue(a, 1'b0, 1'b1, 2'b11, pat(a, 2));
         get_rd(d);
         check(d == shadow[a], $sformatf("R13 old data addr %0d", a), int'(d), int'(shadow[a]));
         shadow[a] = pat(a, 2);
         issue(a, 1'b0, 1'b0, 2'b11, '0);
         get_rd(d);
         check(d == shadow[a], $sformatf("R13 new data addr %0d", a), int'(d), int'(shadow[a]));
      end
      // R7: open row reused
      issue(16, 1'b0, 1'b0, 2'b11, '0);
      get_rd(d);
      r0 = ras_falls;
      issue(17, 1'b0, 1'b0, 2'b11, '0);
      get_rd(d);
      check(ras_falls == r0, "R7 page hit keeps row", ras_falls, r0);
      check(d == shadow[17], "R7 page hit data", int'(d), int'(shadow[17]));
      // R8: other row reopens
      issue(40, 1'b0, 1'b0, 2'b11, '0);
      get_rd(d);
      check(ras_falls == r0 + 1, "R8 row miss reopens", ras_falls, r0 + 1);
      check(d == shadow[40], "R8 row miss data", int'(d), int'(shadow[40]));
      // R10: idle row closes itself
      repeat (T_RAS_MAX + 10) @(negedge clk);
      check(dram_ras_n == 1'b1, "R10 idle row closed", int'(dram_ras_n), 1);
      issue(41, 1'b0, 1'b0, 2'b11, '0);
      get_rd(d);
      check(ras_falls == r0 + 2, "R10 reopen after close", ras_falls, r0 + 2);
      check(d == shadow[41], "R10 reopen data", int'(d), int'(shadow[41]));
      repeat (5) @(negedge clk);

      // pin timing summary from the monitor
      check(v_rcd == 0, "R2 row-to-column delay", v_rcd, 0);
      check(v_width == 0 && cas_pulses > 0, "R3 column pulse width", v_width, 0);
      check(v_early == 0 && wr_pulses > 0, "R5 early write order", v_early, 0);
      check(v_oe == 0, "R5 OE/drive during write", v_oe, 0);
      check(v_min == 0, "R9 minimum row open", v_min, 0);
      check(v_max == 0, "R10 maximum row open", v_max, 0);
      check(v_rp == 0, "R11 row precharge", v_rp, 0);
      check(v_cp == 0, "R12 column precharge", v_cp, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule